// File: doc/BRIEF.md
# Code-Predicting AES Column Transform

This block takes one 32-bit AES state column and applies the byte substitution and then the column mixing step. Beside the result it produces one 4-bit check code per result byte. The codes are not taken from the result. Each code is predicted from the four input bytes alone. The prediction XORs entries of three 256-entry code tables: the code of S(a), the code of S(a)·02 and the code of S(a)·03. A later checker compares these predicted codes with codes recomputed from the transformed data, so that a single flipped bit on the data path can be located and repaired.

The column is accepted when the valid strobe is high. Result and codes appear on registered outputs one clock later. A bypass input drops the mixing step, as the last cipher round needs. The S-box and all three code tables are computed while the design elaborates. No table is read from a file.

Top module: `aes_cp_column`

## Requirements
- R1: With bypass low, the result is MixColumns(SubBytes(column)). Row r of the column is bits [31-8r:24-8r], so row 0 is the most significant byte. Output row r uses the coefficients of matrix row r in (02 03 01 01) rotated right by r. Input 32'h9f825068 gives 32'h8e4da1bc.
- R2: With bypass high, each result byte is S(input byte) and no mixing is done. The S-box is the AES one: GF(2^8) inverse modulo x^8+x^4+x^3+x+1, then the affine map with constant 63. So 00→63, 01→7c, ff→16, 53→ed.
- R3: The check code of a byte b7..b0 is {p3,p2,p1,p0}: p3 = b7^b6^b4^b3^b1, p2 = b7^b5^b4^b2^b1, p1 = b6^b5^b4^b0, p0 = b3^b2^b1^b0. With bypass low, the code for output row r (bits [15-4r:12-4r]) is the XOR of table codes picked by the row's coefficients. It equals the code of output byte r.
- R4: With bypass high, the code for output row r is the code of S(input byte r).
- R5: The valid output equals the valid input of the previous clock edge.
- R6: While the valid input is low, result and codes hold their values, whatever the column and bypass inputs do.
- R7: While reset is asserted, the valid output, result and codes are all zero.
- R8: The reset input is asynchronous and its release passes through two flops. A valid input on the first two clock edges after release is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| in_vld_i | input | 1 | Column valid strobe |
| in_bypass_i | input | 1 | Skip the mixing step (final round) |
| in_col_i | input | 32 | State column, row 0 in the top byte |
| out_vld_o | output | 1 | Result valid, one cycle after the input |
| out_col_o | output | 32 | Transformed column |
| out_code_o | output | 16 | Predicted check codes, row 0 in the top nibble |

## Verification
A sweep rotates every byte value through every lane, once with bypass and once without. It separates a wrong table entry in one lane from a wrong row coefficient or a swapped byte order. A known mixing vector and known S-box corner values pin the absolute result, so an error shared by the design and its predicted codes cannot go unseen. Random columns with random bypass, and runs broken by idle cycles, show that the strobe and the bypass do not leak into held results. A strobe held high right after reset release shows that the synchronizer delays the first capture.

// File: rtl/aes_cp_pkg.sv
package aes_cp_pkg;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned CODE_W  = 4;
  localparam int unsigned NROWS   = 4;
  localparam int unsigned NUM_ENT = 1 << BYTE_W;
  localparam int unsigned COL_W   = NROWS * BYTE_W;
  localparam int unsigned CODES_W = NROWS * CODE_W;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [CODE_W-1:0] code_t;
  typedef byte_t [NUM_ENT-1:0] byte_tab_t;
  typedef code_t [NUM_ENT-1:0] code_tab_t;

  typedef enum logic [1:0] {
    MUL_BY1 = 2'd1,
    MUL_BY2 = 2'd2,
    MUL_BY3 = 2'd3
  } mul_sel_e;

  // multiply by x modulo x^8+x^4+x^3+x+1
  function automatic byte_t gf_dbl(byte_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic byte_t gf_mul(byte_t a, byte_t b);
    byte_t acc;
    byte_t x;
    acc = '0;
    x   = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ x;
      x = gf_dbl(x);
    end
    return acc;
  endfunction

  // a^254 is the inverse (0 maps to 0)
  function automatic byte_t gf_inv(byte_t a);
    byte_t r;
    byte_t p;
    logic [7:0] e;
    r = 8'h01;
    p = a;
    e = 8'hfe;
    for (int i = 0; i < BYTE_W; i++) begin
      if (e[i]) r = gf_mul(r, p);
      p = gf_mul(p, p);
    end
    return r;
  endfunction

  function automatic byte_t rotl8(byte_t b, int unsigned k);
    logic [2*BYTE_W-1:0] dbl;
    dbl = {b, b} >> (BYTE_W - k);
    return dbl[BYTE_W-1:0];
  endfunction

  function automatic byte_t sbox_of(byte_t a);
    byte_t v;
    v = gf_inv(a);
    return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
  endfunction

  function automatic code_t check_code(byte_t b);
    return {b[7] ^ b[6] ^ b[4] ^ b[3] ^ b[1],
            b[7] ^ b[5] ^ b[4] ^ b[2] ^ b[1],
            b[6] ^ b[5] ^ b[4] ^ b[0],
            b[3] ^ b[2] ^ b[1] ^ b[0]};
  endfunction

  function automatic byte_tab_t build_sbox();
    byte_tab_t t;
    for (int i = 0; i < NUM_ENT; i++) t[i] = sbox_of(byte_t'(i));
    return t;
  endfunction

  function automatic code_tab_t build_codes(mul_sel_e m);
    code_tab_t t;
    byte_t     s;
    byte_t     v;
    for (int i = 0; i < NUM_ENT; i++) begin
      s = sbox_of(byte_t'(i));
      case (m)
        MUL_BY2: v = gf_dbl(s);
        MUL_BY3: v = gf_dbl(s) ^ s;
        default: v = s;
      endcase
      t[i] = check_code(v);
    end
    return t;
  endfunction

  // circulant mixing matrix: row r is (02 03 01 01) rotated right by r
  function automatic mul_sel_e row_coef(int r, int k);
    int d;
    d = (k - r + int'(NROWS)) % int'(NROWS);
    if (d == 0) return MUL_BY2;
    if (d == 1) return MUL_BY3;
    return MUL_BY1;
  endfunction

endpackage

// File: rtl/aes_cp_rst_sync.sv
module aes_cp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/aes_cp_sbox_lane.sv
module aes_cp_sbox_lane
  import aes_cp_pkg::*;
(
  input  byte_t din_i,
  output byte_t s1_o,
  output byte_t s2_o,
  output byte_t s3_o,
  output code_t c1_o,
  output code_t c2_o,
  output code_t c3_o
);

  localparam byte_tab_t SUB_TAB = build_sbox();
  localparam code_tab_t K1_TAB  = build_codes(MUL_BY1);
  localparam code_tab_t K2_TAB  = build_codes(MUL_BY2);
  localparam code_tab_t K3_TAB  = build_codes(MUL_BY3);

  always_comb begin
    s1_o = SUB_TAB[din_i];
    s2_o = gf_dbl(s1_o);
    s3_o = s2_o ^ s1_o;
    // codes are indexed by the input byte, never derived from s*_o
    c1_o = K1_TAB[din_i];
    c2_o = K2_TAB[din_i];
    c3_o = K3_TAB[din_i];
  end

endmodule

// File: rtl/aes_cp_mix.sv
module aes_cp_mix
  import aes_cp_pkg::*;
(
  input  logic                  bypass_i,
  input  byte_t [NROWS-1:0]     s1_i,
  input  byte_t [NROWS-1:0]     s2_i,
  input  byte_t [NROWS-1:0]     s3_i,
  input  code_t [NROWS-1:0]     c1_i,
  input  code_t [NROWS-1:0]     c2_i,
  input  code_t [NROWS-1:0]     c3_i,
  output byte_t [NROWS-1:0]     res_o,
  output code_t [NROWS-1:0]     code_o
);

  for (genvar r = 0; r < NROWS; r++) begin : g_row
    always_comb begin
      byte_t acc;
      code_t cacc;
      acc  = '0;
      cacc = '0;
      for (int k = 0; k < NROWS; k++) begin
        case (row_coef(r, k))
          MUL_BY2: begin
            acc  = acc ^ s2_i[k];
            cacc = cacc ^ c2_i[k];
          end
          MUL_BY3: begin
            acc  = acc ^ s3_i[k];
            cacc = cacc ^ c3_i[k];
          end
          default: begin
            acc  = acc ^ s1_i[k];
            cacc = cacc ^ c1_i[k];
          end
        endcase
      end
      if (bypass_i) begin
        res_o[r]  = s1_i[r];
        code_o[r] = c1_i[r];
      end else begin
        res_o[r]  = acc;
        code_o[r] = cacc;
      end
    end
  end

endmodule

// File: rtl/aes_cp_column.sv
module aes_cp_column
  import aes_cp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_vld_i,
  input  logic               in_bypass_i,
  input  logic [COL_W-1:0]   in_col_i,
  output logic               out_vld_o,
  output logic [COL_W-1:0]   out_col_o,
  output logic [CODES_W-1:0] out_code_o
);

  logic              rst_sync_n;
  byte_t [NROWS-1:0] lane_in;
  byte_t [NROWS-1:0] sub1, sub2, sub3;
  code_t [NROWS-1:0] kc1, kc2, kc3;
  byte_t [NROWS-1:0] mix_res;
  code_t [NROWS-1:0] mix_code;

  logic               vld_d, vld_q;
  logic [COL_W-1:0]   col_d, col_q;
  logic [CODES_W-1:0] code_d, code_q;

  aes_cp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  for (genvar r = 0; r < NROWS; r++) begin : g_lane
    assign lane_in[r] = in_col_i[COL_W-1-r*BYTE_W -: BYTE_W];

    aes_cp_sbox_lane u_lane (
      .din_i (lane_in[r]),
      .s1_o  (sub1[r]),
      .s2_o  (sub2[r]),
      .s3_o  (sub3[r]),
      .c1_o  (kc1[r]),
      .c2_o  (kc2[r]),
      .c3_o  (kc3[r])
    );
  end

  aes_cp_mix u_mix (
    .bypass_i (in_bypass_i),
    .s1_i     (sub1),
    .s2_i     (sub2),
    .s3_i     (sub3),
    .c1_i     (kc1),
    .c2_i     (kc2),
    .c3_i     (kc3),
    .res_o    (mix_res),
    .code_o   (mix_code)
  );

  // next-state
  always_comb begin
    vld_d = in_vld_i;
    for (int r = 0; r < NROWS; r++) begin
      col_d[COL_W-1-r*BYTE_W -: BYTE_W]    = mix_res[r];
      code_d[CODES_W-1-r*CODE_W -: CODE_W] = mix_code[r];
    end
  end

  // registers, data loaded under the valid strobe
  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q  <= 1'b0;
      col_q  <= '0;
      code_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (in_vld_i) begin
        col_q  <= col_d;
        code_q <= code_d;
      end
    end
  end

  assign out_vld_o  = vld_q;
  assign out_col_o  = col_q;
  assign out_code_o = code_q;

endmodule

// File: rtl/aes_cp_column_chk.sv
module aes_cp_column_chk
  import aes_cp_pkg::*;
(
  input logic               clk,
  input logic               rst_sn,
  input logic               in_vld,
  input logic               in_bypass,
  input logic [COL_W-1:0]   in_col,
  input logic               out_vld,
  input logic [COL_W-1:0]   out_col,
  input logic [CODES_W-1:0] out_code
);

  function automatic logic [CODES_W-1:0] codes_of(logic [COL_W-1:0] c);
    logic [CODES_W-1:0] k;
    for (int r = 0; r < NROWS; r++)
      k[CODES_W-1-r*CODE_W -: CODE_W] = check_code(c[COL_W-1-r*BYTE_W -: BYTE_W]);
    return k;
  endfunction

  function automatic logic [COL_W-1:0] subst_of(logic [COL_W-1:0] c);
    logic [COL_W-1:0] s;
    for (int r = 0; r < NROWS; r++)
      s[COL_W-1-r*BYTE_W -: BYTE_W] = sbox_of(c[COL_W-1-r*BYTE_W -: BYTE_W]);
    return s;
  endfunction

  AST_VLD_DELAY: assert property (@(posedge clk) disable iff (!rst_sn)
    $past(rst_sn) |-> (out_vld == $past(in_vld))); // R5

  AST_CODE_MATCH: assert property (@(posedge clk) disable iff (!rst_sn)
    out_vld |-> (out_code == codes_of(out_col))); // R3 R4

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_sn)
    ($past(rst_sn) && !$past(in_vld)) |-> ($stable(out_col) && $stable(out_code))); // R6

  AST_BYPASS_SUB: assert property (@(posedge clk) disable iff (!rst_sn)
    ($past(rst_sn) && $past(in_vld) && $past(in_bypass)) |-> (out_col == subst_of($past(in_col)))); // R2

  AST_RST_IDLE: assert property (@(posedge clk)
    !rst_sn |-> (!out_vld && out_col == '0 && out_code == '0)); // R7

endmodule

bind aes_cp_column aes_cp_column_chk u_chk (
  .clk       (clk_i),
  .rst_sn    (rst_sync_n),
  .in_vld    (in_vld_i),
  .in_bypass (in_bypass_i),
  .in_col    (in_col_i),
  .out_vld   (out_vld_o),
  .out_col   (out_col_o),
  .out_code  (out_code_o)
);

// File: tb/aes_cp_column_tb_top.sv
`timescale 1ns/1ps
module aes_cp_column_tb_top;

  logic        clk;
  logic        rst_ni;
  logic        in_vld;
  logic        in_bypass;
  logic [31:0] in_col;
  logic        out_vld;
  logic [31:0] out_col;
  logic [15:0] out_code;

  int n_chk;
  int n_bad;
  bit done;

  logic [7:0] exp_t [256];
  int         log_t [256];

  aes_cp_column dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .in_vld_i    (in_vld),
    .in_bypass_i (in_bypass),
    .in_col_i    (in_col),
    .out_vld_o   (out_vld),
    .out_col_o   (out_col),
    .out_code_o  (out_code)
  );

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  function automatic logic [7:0] xt(logic [7:0] a);
    return a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
  endfunction

  function automatic logic [7:0] ref_sub(logic [7:0] a);
    logic [7:0] b;
    logic [7:0] o;
    logic [7:0] c;
    c = 8'h63;
    b = (a == 8'h00) ? 8'h00 : exp_t[(255 - log_t[a]) % 255];
    for (int i = 0; i < 8; i++)
      o[i] = b[i] ^ b[(i+4)%8] ^ b[(i+5)%8] ^ b[(i+6)%8] ^ b[(i+7)%8] ^ c[i];
    return o;
  endfunction

  function automatic logic [3:0] ref_code(logic [7:0] b);
    logic [3:0] k;
    k[3] = b[7] ^ b[6] ^ b[4] ^ b[3] ^ b[1];
    k[2] = b[7] ^ b[5] ^ b[4] ^ b[2] ^ b[1];
    k[1] = b[6] ^ b[5] ^ b[4] ^ b[0];
    k[0] = b[3] ^ b[2] ^ b[1] ^ b[0];
    return k;
  endfunction

  function automatic logic [31:0] ref_col(logic [31:0] c, bit byp);
    logic [7:0] s0, s1, s2, s3;
    s0 = ref_sub(c[31:24]);
    s1 = ref_sub(c[23:16]);
    s2 = ref_sub(c[15:8]);
    s3 = ref_sub(c[7:0]);
    if (byp) return {s0, s1, s2, s3};
    return {xt(s0) ^ xt(s1) ^ s1 ^ s2 ^ s3,
            s0 ^ xt(s1) ^ xt(s2) ^ s2 ^ s3,
            s0 ^ s1 ^ xt(s2) ^ xt(s3) ^ s3,
            xt(s0) ^ s0 ^ s1 ^ s2 ^ xt(s3)};
  endfunction

  function automatic logic [15:0] ref_codes(logic [31:0] r);
    return {ref_code(r[31:24]), ref_code(r[23:16]), ref_code(r[15:8]), ref_code(r[7:0])};
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  logic [31:0] last_res;
  logic [15:0] last_code;

  // drive one column, sample after the capturing edge
  task automatic apply(logic [31:0] c, bit byp);
    @(negedge clk);
    in_vld    = 1'b1;
    in_col    = c;
    in_bypass = byp;
    @(posedge clk);
    #1;
    last_res  = ref_col(c, byp);
    last_code = ref_codes(last_res);
    check(byp ? "R2" : "R1", "result", out_col, last_res);
    check(byp ? "R4" : "R3", "codes", {16'h0, out_code}, {16'h0, last_code});
    check("R5", "valid", {31'h0, out_vld}, 32'h1);
  endtask

  task automatic idle_cycles(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld    = 1'b0;
      in_col    = $urandom;
      in_bypass = ~in_bypass;
      @(posedge clk);
      #1;
      check("R5", "valid idle", {31'h0, out_vld}, 32'h0);
      check("R6", "held result", out_col, last_res);
      check("R6", "held codes", {16'h0, out_code}, {16'h0, last_code});
    end
  endtask

  initial begin
    logic [7:0] e;
    e = 8'h01;
    for (int i = 0; i < 255; i++) begin
      exp_t[i] = e;
      log_t[e] = i;
      e = xt(e) ^ e;
    end
    exp_t[255] = 8'h01;
    log_t[0]   = 0;
  end

  initial begin
    logic [31:0] seed;
    n_chk = 0;
    n_bad = 0;
    done  = 1'b0;
    seed  = $urandom(32'h5eed_0c01);
    rst_ni    = 1'b1;
    in_vld    = 1'b0;
    in_bypass = 1'b0;
    in_col    = 32'h0;
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R7", "valid in reset", {31'h0, out_vld}, 32'h0);
    check("R7", "result in reset", out_col, 32'h0);
    check("R7", "codes in reset", {16'h0, out_code}, 32'h0);

    // release with the strobe already high: two edges must be ignored
    @(negedge clk);
    rst_ni    = 1'b1;
    in_vld    = 1'b1;
    in_col    = 32'h1234_5678;
    in_bypass = 1'b0;
    @(posedge clk);
    @(posedge clk);
    #1;
    check("R8", "valid after release", {31'h0, out_vld}, 32'h0);
    @(negedge clk);
    in_vld = 1'b0;
    @(posedge clk);
    #1;
    check("R8", "valid not captured", {31'h0, out_vld}, 32'h0);
    check("R8", "result not captured", out_col, 32'h0);

    // known answers
    apply(32'h9f82_5068, 1'b0);
    check("R1", "mix known answer", out_col, 32'h8e4d_a1bc);
    apply(32'h0001_ff53, 1'b1);
    check("R2", "sbox known answer", out_col, 32'h637c_16ed);
    apply(32'h0000_0000, 1'b0);
    apply(32'hffff_ffff, 1'b1);
    idle_cycles(3);

    // every byte value through every lane, both modes
    for (int m = 0; m < 2; m++) begin
      for (int v = 0; v < 256; v++) begin
        logic [7:0] b;
        b = 8'(v);
        apply({b, b + 8'd85, b + 8'd170, b + 8'd255}, m[0]);
      end
    end

    // random columns, random bypass, occasional gaps
    for (int i = 0; i < 400; i++) begin
      apply($urandom, 1'($urandom));
      if (($urandom % 16) == 0) idle_cycles(1 + int'($urandom % 3));
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R5 watchdog: actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule